// File: doc/BRIEF.md
# Configurable Serial Stereo Audio Transmitter

This block serialises stereo PCM sample pairs onto a single data line, together with a bit clock and a word clock that marks the left and right channels. Samples are sent MSB first. Each channel slot lasts exactly `W` bit clocks, and the left word of a pair always goes out before its right word. A one-entry holding register, loaded through a valid/ready handshake, supplies a new pair at the start of every left slot. When no pair is waiting, the block sends zeros for that frame and pulses an underrun flag.

Four configuration inputs select the operating mode at run time:

- **Clock role.** In master mode the block divides its system clock to drive the bit and word clocks. In slave mode it samples externally supplied clocks through synchronisers and follows them.
- **Launch edge.** Selects which bit clock edge changes the word clock and the data.
- **Word clock sense.** Selects which word clock level means "left".
- **Frame timing.** Selects whether the word clock changes together with the MSB (aligned) or one bit clock earlier (delayed).

The configuration is captured only while the enable input is low. Disabling the block silences the data line, parks the master clocks and restarts the frame.

Top module: `i2s_tx`

## Requirements
- R1: After reset, `sd_out` = 0, `clk_oe` = 0, `underrun` = 0 and `s_ready` = 1. All configuration defaults to 0: slave role, aligned timing, falling-edge launch, and word clock low meaning left. Because of these defaults, `sck_out` idles at 0 and `ws_out` idles at 1.
- R2: In master mode with `en` high, `clk_oe` = 1. Consecutive launch edges of `sck_out` are exactly `DIV` system clocks apart. `ws_out` changes once every `W` bit clocks.
- R3: Each channel slot carries `W` bits, MSB first. For every accepted pair, the left word is sent, then the right word.
- R4: With `cfg_ws_lead` = 0, the word clock transition coincides with the MSB of the new slot. With `cfg_ws_lead` = 1, it occurs one bit clock earlier, during the LSB of the previous slot.
- R5: With `cfg_sck_rise` = 1, the word clock and data change on the rising bit clock edge and are valid at the falling edge. With `cfg_sck_rise` = 0, they change on the falling edge and are valid at the rising edge.
- R6: With `cfg_ws_inv` = 0, a low word clock marks the left channel and a high word clock marks the right channel. With `cfg_ws_inv` = 1, this mapping is inverted.
- R7: In slave mode, `sck_in` and `ws_in` pass through two-flop synchronisers. `sd_out` settles no later than 3 system clocks after a launching edge of `sck_in`, so the system clock must run at least 8x the bit clock. No data is sent until the first word clock change into the left channel has been seen.
- R8: `s_ready` is high exactly while the holding register is empty. The held pair is moved into the frame only at the start of a left slot.
- R9: If the holding register is empty at the start of a left slot, that whole frame carries zero data, and `underrun` is high for exactly one system clock.
- R10: The configuration inputs are captured only while `en` is low. Changes made while `en` is high have no effect on the output.
- R11: While `en` is low: `sd_out` = 0 and `clk_oe` = 0, `sck_out` rests at the level equal to `cfg_sck_rise`, and `ws_out` rests on the right-channel level. The next enable restarts the frame from its first position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmit enable; configuration loads while low |
| cfg_master | input | 1 | 1 = drive the clocks, 0 = follow external clocks |
| cfg_ws_lead | input | 1 | 1 = word clock leads the MSB by one bit |
| cfg_sck_rise | input | 1 | 1 = launch on rising bit clock edge |
| cfg_ws_inv | input | 1 | 1 = word clock high means left |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register empty |
| s_left | input | W | Left sample |
| s_right | input | W | Right sample |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word clock (slave) |
| sck_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word clock (master) |
| clk_oe | output | 1 | High while the block drives the clocks |
| sd_out | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse when a frame starts with no pair |

## Verification
The hardest situation to reach is slave operation at the minimum clock ratio. It needs an external word clock whose first transition locks the frame, in both timing variants, and data that must already be stable half a bit clock after each launch edge. The bench acts as an external clock master with a half period of four system clocks. It idles on the right channel for one slot before the first left transition, and its receiver samples on the opposite edge, so a single extra cycle of latency or a wrong lock position corrupts the decoded words. Underrun frames are reached by letting the driver stop feeding pairs while the clocks keep running.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    // Run-time configuration, captured while the block is disabled
    typedef struct packed {
        logic master;    // 1: block drives bit and word clocks
        logic delay1;    // 1: word clock leads MSB by one bit
        logic sck_rise;  // 1: launch on rising bit clock edge
        logic ws_inv;    // 1: high word clock means left
    } tx_cfg_t;

    localparam tx_cfg_t CFG_RESET = '0;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Physical word clock level for a logical channel
    function automatic logic ws_level(chan_e ch, logic inv);
        return logic'(ch) ^ inv;
    endfunction

endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
    import i2s_tx_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  tx_cfg_t cfg,
    input  logic    sck_in,
    input  logic    ws_in,
    output logic    tick,
    output chan_e   ext_chan,
    output logic    sck_drv
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic       ph;
    logic       wrap;
    logic [2:0] sck_sync;
    logic [1:0] ws_sync;

    // Half-period counter; a divide-by-two needs no counter at all
    generate
        if (HALF == 1) begin : g_no_cnt
            assign wrap = 1'b1;
        end else begin : g_cnt
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || !en || !cfg.master) begin
                    cnt <= '0;
                end else if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign wrap = (cnt == CW'(HALF - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !en || !cfg.master) begin
            ph <= 1'b0;
        end else if (wrap) begin
            ph <= ~ph;
        end
    end

    // External clocks: two-flop synchronisers plus one history flop
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= '0;
            ws_sync  <= '0;
        end else begin
            sck_sync <= {sck_sync[1:0], sck_in};
            ws_sync  <= {ws_sync[0], ws_in};
        end
    end

    logic m_tick, s_tick, s_rise, s_fall;
    assign s_rise   = sck_sync[1] & ~sck_sync[2];
    assign s_fall   = ~sck_sync[1] & sck_sync[2];
    assign m_tick   = en && cfg.master && wrap && ph;
    assign s_tick   = en && !cfg.master && (cfg.sck_rise ? s_rise : s_fall);
    assign tick     = m_tick | s_tick;
    assign sck_drv  = ph ^ cfg.sck_rise;
    assign ext_chan = chan_e'(ws_sync[1] ^ cfg.ws_inv);

    // R2/R5: after a master launch the bit clock sits at the launch level
    a_r2_launch_level: assert property (@(posedge clk) disable iff (rst)
        (tick && cfg.master) |=> (sck_drv == cfg.sck_rise));

endmodule

// File: rtl/i2s_tx_hold.sv
module i2s_tx_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_left,
    input  logic [W-1:0] in_right,
    input  logic         take,
    output logic         have,
    output logic [W-1:0] out_left,
    output logic [W-1:0] out_right
);
    logic full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full      <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else if (in_valid && !full) begin
            full      <= 1'b1;
            out_left  <= in_left;
            out_right <= in_right;
        end else if (take) begin
            full      <= 1'b0;
        end
    end

    assign in_ready = !full;
    assign have     = full;

    // R8: a held pair is kept intact until the frame takes it
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(out_left) && $stable(out_right)));

endmodule

// File: rtl/i2s_tx_frame.sv
module i2s_tx_frame
    import i2s_tx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  tx_cfg_t      cfg,
    input  logic         tick,
    input  chan_e        ext_chan,
    input  logic         hold_have,
    input  logic [W-1:0] hold_left,
    input  logic [W-1:0] hold_right,
    output logic         take,
    output logic         sd_out,
    output chan_e        ws_ch,
    output logic         underrun
);
    localparam int FW = 2 * W;
    localparam int DW = $clog2(FW);
    typedef logic [DW-1:0] pos_t;

    function automatic pos_t inc_pos(pos_t p);
        return (p == pos_t'(FW - 1)) ? '0 : p + 1'b1;
    endfunction

    pos_t          d, d_n, lead, idx, d_init;
    logic [FW-1:0] frame, next_frame;
    logic          locked, adv, load, enter_left, enter_right;
    chan_e         prev_ch, next_ch;

    assign enter_left  = (ext_chan == CH_LEFT)  && (prev_ch == CH_RIGHT);
    assign enter_right = (ext_chan == CH_RIGHT) && (prev_ch == CH_LEFT);
    assign d_init      = cfg.delay1 ? pos_t'(FW - 2) : pos_t'(FW - 1);

    always_comb begin
        d_n = inc_pos(d);
        adv = tick;
        if (!cfg.master) begin
            if (enter_left) begin
                d_n = cfg.delay1 ? pos_t'(FW - 1) : '0;
            end else if (enter_right && locked) begin
                d_n = cfg.delay1 ? pos_t'(W - 1) : pos_t'(W);
            end
            adv = tick && (locked || enter_left);
        end
        load       = adv && (d_n == '0);
        lead       = cfg.delay1 ? inc_pos(d_n) : d_n;
        next_ch    = (lead >= pos_t'(W)) ? CH_RIGHT : CH_LEFT;
        next_frame = frame;
        if (load) begin
            next_frame = hold_have ? {hold_left, hold_right} : '0;
        end
        idx = pos_t'(FW - 1) - d_n;
    end

    assign take = load && hold_have;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            d        <= d_init;
            frame    <= '0;
            sd_out   <= 1'b0;
            ws_ch    <= CH_RIGHT;
            locked   <= 1'b0;
            prev_ch  <= CH_RIGHT;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (tick) begin
                prev_ch <= ext_chan;
            end
            if (adv) begin
                d        <= d_n;
                frame    <= next_frame;
                sd_out   <= next_frame[idx];
                ws_ch    <= next_ch;
                underrun <= load && !hold_have;
                if (enter_left) begin
                    locked <= 1'b1;
                end
            end
        end
    end

    // R9: underrun is a single-cycle pulse
    a_r9_one_pulse: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun);

    // R4: a master frame load always coincides with the left word clock
    a_r4_left_at_load: assert property (@(posedge clk) disable iff (rst)
        (en && cfg.master && load) |=> (ws_ch == CH_LEFT));

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
    import i2s_tx_pkg::*;
#(
    parameter int W   = 16,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         cfg_master,
    input  logic         cfg_ws_lead,
    input  logic         cfg_sck_rise,
    input  logic         cfg_ws_inv,
    input  logic         s_valid,
    output logic         s_ready,
    input  logic [W-1:0] s_left,
    input  logic [W-1:0] s_right,
    input  logic         sck_in,
    input  logic         ws_in,
    output logic         sck_out,
    output logic         ws_out,
    output logic         clk_oe,
    output logic         sd_out,
    output logic         underrun
);
    tx_cfg_t      cfg_q;
    logic         tick, take, have;
    chan_e        ext_chan, ws_ch;
    logic [W-1:0] h_left, h_right;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (!en) begin
            cfg_q <= '{master: cfg_master, delay1: cfg_ws_lead,
                       sck_rise: cfg_sck_rise, ws_inv: cfg_ws_inv};
        end
    end

    i2s_tx_clkgen #(.DIV(DIV)) u_clk (
        .clk(clk), .rst(rst), .en(en), .cfg(cfg_q),
        .sck_in(sck_in), .ws_in(ws_in),
        .tick(tick), .ext_chan(ext_chan), .sck_drv(sck_out)
    );

    i2s_tx_hold #(.W(W)) u_hold (
        .clk(clk), .rst(rst),
        .in_valid(s_valid), .in_ready(s_ready),
        .in_left(s_left), .in_right(s_right),
        .take(take), .have(have),
        .out_left(h_left), .out_right(h_right)
    );

    i2s_tx_frame #(.W(W)) u_frame (
        .clk(clk), .rst(rst), .en(en), .cfg(cfg_q),
        .tick(tick), .ext_chan(ext_chan),
        .hold_have(have), .hold_left(h_left), .hold_right(h_right),
        .take(take), .sd_out(sd_out), .ws_ch(ws_ch), .underrun(underrun)
    );

    assign ws_out = ws_level(ws_ch, cfg_q.ws_inv);
    assign clk_oe = en && cfg_q.master;

    // R10: configuration does not move while enabled
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(cfg_q));

endmodule

// File: tb/test_i2s_tx.sv
module test_i2s_tx;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int DIV = 4;
    localparam int H   = 4;   // slave half bit period in system clocks (8x)

    logic clk = 1'b0, rst = 1'b1, en = 1'b0;
    logic cfg_master = 0, cfg_ws_lead = 0, cfg_sck_rise = 0, cfg_ws_inv = 0;
    logic s_valid = 0, s_ready;
    logic [W-1:0] s_left = '0, s_right = '0;
    logic ext_sck = 0, ext_ws = 1;
    logic sck_out, ws_out, clk_oe, sd_out, underrun;

    int tests = 0, fails = 0;

    i2s_tx #(.W(W), .DIV(DIV)) i_i2s_tx (
        .clk(clk), .rst(rst), .en(en),
        .cfg_master(cfg_master), .cfg_ws_lead(cfg_ws_lead),
        .cfg_sck_rise(cfg_sck_rise), .cfg_ws_inv(cfg_ws_inv),
        .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .sck_in(ext_sck), .ws_in(ext_ws),
        .sck_out(sck_out), .ws_out(ws_out), .clk_oe(clk_oe),
        .sd_out(sd_out), .underrun(underrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard: expected {channel(1=right), word}
    logic [W:0] expq[$];
    string run_tag = "";

    // Monitor state
    bit   mon_on = 0, mon_master = 0, mon_delay = 0, mon_sp = 0, mon_wp = 0;
    logic prev_sck, prev_ws;
    bit   pend = 0, collecting = 0;
    int   nbits = 0, zero_words = 0, und_cnt = 0;
    logic [W-1:0] word;
    logic cur_ch;

    always @(negedge clk) begin
        if (mon_on && underrun) und_cnt++;
    end

    always @(negedge clk) begin
        logic bsck, bws, vedge, changed, start;
        logic [W:0] e;
        if (mon_on) begin
            bsck  = mon_master ? sck_out : ext_sck;
            bws   = mon_master ? ws_out  : ext_ws;
            vedge = mon_sp ? (prev_sck & ~bsck) : (~prev_sck & bsck);
            prev_sck = bsck;
            if (vedge) begin
                changed = (bws != prev_ws);
                prev_ws = bws;
                start   = mon_delay ? pend : changed;
                pend    = changed;
                if (start) begin
                    collecting = 1;
                    nbits      = 0;
                    cur_ch     = bws ^ mon_wp;
                end
                if (collecting) begin
                    word = {word[W-2:0], sd_out};
                    nbits++;
                    if (nbits == W) begin
                        collecting = 0;
                        if (expq.size() > 0) begin
                            e = expq.pop_front();
                            check(word == e[W-1:0], run_tag, "word value R3",
                                  int'(word), int'(e[W-1:0]));
                            check(cur_ch == e[W], "R6", "channel", int'(cur_ch), int'(e[W]));
                        end else begin
                            zero_words++;
                            check(word == '0, "R9", "underrun word", int'(word), 0);
                        end
                    end
                end
            end
        end
    end

    task automatic push_pair(input logic [W-1:0] l, input logic [W-1:0] r);
        @(posedge clk); #1;
        s_valid = 1; s_left = l; s_right = r;
        forever begin
            if (s_ready) begin
                @(posedge clk);
                expq.push_back({1'b0, l});
                expq.push_back({1'b1, r});
                break;
            end
            @(posedge clk); #1;
        end
        #1 s_valid = 0;
    endtask

    task automatic mon_start(input bit m, input bit dl, input bit sp, input bit wp);
        mon_master = m; mon_delay = dl; mon_sp = sp; mon_wp = wp;
        prev_sck = m ? sp : ~sp;
        prev_ws  = 1'b1 ^ wp;
        pend = 0; collecting = 0; nbits = 0;
        zero_words = 0; und_cnt = 0;
        expq.delete();
        mon_on = 1;
    endtask

    task automatic run_master(input bit dl, input bit sp, input bit wp,
                              input logic [W-1:0] base, input bit flip);
        int cnt;
        @(posedge clk); #1;
        en = 0; cfg_master = 1; cfg_ws_lead = dl; cfg_sck_rise = sp; cfg_ws_inv = wp;
        repeat (3) @(posedge clk);
        #1;
        run_tag = "R3 R4 R5";
        mon_start(1, dl, sp, wp);
        push_pair(base, ~base);
        @(posedge clk); #1 en = 1;
        if (flip) begin   // R10: changes while enabled must be ignored
            cfg_ws_inv = ~wp; cfg_sck_rise = ~sp; cfg_ws_lead = ~dl;
        end
        // R2: launch-to-launch spacing
        @(negedge clk);
        while (!(sck_out == sp && prev_sck != sp)) @(negedge clk);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!(sck_out == sp && prev_sck != sp));
        check(cnt == DIV, "R2", "bit clock period", cnt, DIV);
        check(clk_oe == 1, "R2", "clk_oe in master", int'(clk_oe), 1);
        push_pair(base + 8'h11, base ^ 8'h5A);
        push_pair(8'h80, 8'h01);
        repeat (4 * 2 * W * DIV) @(posedge clk);
        #1 mon_on = 0;
        check(expq.size() == 0, "R3", "words left unsent", expq.size(), 0);
        check(zero_words >= 1, "R9", "zero frame after pairs ran out", zero_words, 1);
        check(und_cnt >= 1, "R9", "underrun pulses", und_cnt, 1);
        en = 0;
    endtask

    function automatic logic ext_chan_of(input int k, input bit dl);
        int ka;
        ka = k + int'(dl);
        return ((ka / W) % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic gen_ext(input int nbits_total, input bit dl, input bit sp, input bit wp);
        for (int k = 0; k < nbits_total; k++) begin
            ext_sck = sp;
            ext_ws  = ext_chan_of(k, dl) ^ wp;
            repeat (H) @(posedge clk);
            #1 ext_sck = ~sp;
            repeat (H) @(posedge clk);
            #1;
        end
    endtask

    task automatic run_slave(input bit dl, input bit sp, input bit wp,
                             input logic [W-1:0] base);
        @(posedge clk); #1;
        en = 0; cfg_master = 0; cfg_ws_lead = dl; cfg_sck_rise = sp; cfg_ws_inv = wp;
        ext_sck = ~sp; ext_ws = 1'b1 ^ wp;
        repeat (5) @(posedge clk);
        #1;
        run_tag = "R7 R4 R5";
        mon_start(0, dl, sp, wp);
        push_pair(base, base + 8'h3C);
        @(posedge clk); #1 en = 1;
        check(clk_oe == 0, "R7", "clk_oe in slave", int'(clk_oe), 0);
        @(posedge clk); #1;
        fork
            gen_ext(W + 2 * W * 5, dl, sp, wp);
            begin
                push_pair(~base, 8'hC3);
                push_pair(8'h7F, 8'hFE);
            end
        join
        mon_on = 0;
        check(expq.size() == 0, "R7", "words left unsent", expq.size(), 0);
        check(und_cnt >= 1, "R9", "underrun pulses slave", und_cnt, 1);
        en = 0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic s0, w0;
        repeat (5) @(posedge clk);
        #1 rst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sd_out == 0,   "R1", "sd_out after reset", int'(sd_out), 0);
        check(clk_oe == 0,   "R1", "clk_oe after reset", int'(clk_oe), 0);
        check(underrun == 0, "R1", "underrun after reset", int'(underrun), 0);
        check(s_ready == 1,  "R8", "ready when empty", int'(s_ready), 1);
        check(sck_out == 0,  "R1", "default sck idle", int'(sck_out), 0);
        check(ws_out == 1,   "R1", "default ws idle right", int'(ws_out), 1);

        run_master(0, 0, 0, 8'hA5, 0);
        run_master(1, 1, 0, 8'h3C, 0);
        run_master(0, 1, 1, 8'hF0, 1);
        run_master(1, 0, 1, 8'h96, 1);

        // R11: idle behaviour after disable (inputs hold last-written values)
        repeat (3) @(posedge clk);
        @(negedge clk);
        s0 = sck_out; w0 = ws_out;
        check(sd_out == 0, "R11", "sd_out while disabled", int'(sd_out), 0);
        check(clk_oe == 0, "R11", "clk_oe while disabled", int'(clk_oe), 0);
        check(sck_out == cfg_sck_rise, "R11", "sck idle level", int'(sck_out), int'(cfg_sck_rise));
        check(ws_out == (1'b1 ^ cfg_ws_inv), "R11", "ws idle level", int'(ws_out),
              int'(1'b1 ^ cfg_ws_inv));
        repeat (20) @(negedge clk);
        check(sck_out == s0 && ws_out == w0, "R11", "clocks stopped",
              int'({sck_out, ws_out}), int'({s0, w0}));

        run_slave(0, 0, 0, 8'h5A);
        run_slave(1, 1, 1, 8'h21);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule